// File: doc/BRIEF.md
# Receive FIFO Idle Timeout Detector

This block watches a FIFO-mode serial receiver and raises an interrupt when characters have been waiting in the receive FIFO too long without service. While the FIFO holds data, it counts oversampling ticks (one per sixteenth of a bit time by default). The count restarts when the receiver reports the middle of a stop bit, when the CPU reads the holding register, or when the frame format changes. The interrupt fires when the count reaches four whole character times for the programmed frame format. That format is set by the word length, the parity enable and the stop-bit length, and a half stop bit counts as half a bit time.

The interrupt is level-held. It clears when the CPU reads the holding register or when the FIFO runs empty. A system uses it to drain a FIFO that holds fewer bytes than the receive trigger level at the end of a burst. The receiver, the FIFO and the baud generator sit outside this block.

Top module: `uart_rx_timeout`

## Requirements
- R1: While `fifo_empty_i` is 1 the counter is held at zero, `timeout_irq_o` is 0 one cycle later, and it never rises however many ticks arrive.
- R2: A cycle with `stop_mid_i` = 1 restarts the count from zero; a full new limit of ticks is then needed before `timeout_irq_o` rises.
- R3: A cycle with `rhr_rd_i` = 1 restarts the count from zero and clears `timeout_irq_o` on the next cycle.
- R4: The limit in ticks is 4 × (16 × (1 + W + P) + S), where W = 5 + `word_len_i` (code 0..3 gives 5..8 bits), P = `parity_en_i`, and S = 16, 24 or 32 for `stop_sel_i` = 0, 1 or 2 (code 3 also gives 32). `timeout_irq_o` is 0 after limit−1 counted ticks and 1 in the cycle after the limit-th tick.
- R5: Only cycles with `tick_i` = 1 advance the count; idle cycles in between neither advance nor reset it.
- R6: Any change of `word_len_i`, `parity_en_i` or `stop_sel_i` restarts the count from zero in the cycle it is seen.
- R7: Once raised, `timeout_irq_o` stays 1 through further ticks and stop-bit strobes until a read (R3) or an empty FIFO (R1).
- R8: A synchronous `rst` clears the count and drives `timeout_irq_o` to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oversampling tick, one per sixteenth of a bit time |
| word_len_i | input | 2 | Data bits minus five |
| parity_en_i | input | 1 | Parity bit present in the frame |
| stop_sel_i | input | 2 | Stop length: 0 = one, 1 = one and a half, 2 or 3 = two |
| fifo_empty_i | input | 1 | Receive FIFO holds no data |
| stop_mid_i | input | 1 | Receiver strobe at the centre of a stop bit |
| rhr_rd_i | input | 1 | CPU read strobe of the receive holding register |
| timeout_irq_o | output | 1 | Receive timeout interrupt, level |

## Verification
The bench builds the block with its default parameters: sixteen ticks per bit and a four-character window. Every limit therefore falls between 448 and 768 ticks, so each boundary can be hit tick-exact in a short run. Those values cover the shortest frame, the longest frame and the half-stop-bit frame, plus restarts placed well past the shorter limits, so a missed restart shows up as an early interrupt.

// File: rtl/uart_rx_timeout_pkg.sv
package uart_rx_timeout_pkg;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2,
        STOP_TWO_ALT  = 2'd3
    } stop_len_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par;
        stop_len_e  stop;
    } frame_fmt_t;

    // Ticks spent on the stop bits of one character.
    function automatic int stop_ticks(stop_len_e s, int tpb);
        case (s)
            STOP_ONE:      return tpb;
            STOP_ONE_HALF: return tpb + tpb / 2;
            default:       return 2 * tpb;
        endcase
    endfunction

    // Ticks in the whole idle window for a frame format.
    function automatic int window_ticks(frame_fmt_t f, int tpb, int nchar);
        int bits;
        bits = 1 + 5 + int'(f.wlen) + int'(f.par);
        return nchar * (bits * tpb + stop_ticks(f.stop, tpb));
    endfunction

    // Largest window over all formats: 12 bit times per character.
    function automatic int window_max(int tpb, int nchar);
        return nchar * tpb * 12;
    endfunction

endpackage

// File: rtl/tmo_limit_calc.sv
module tmo_limit_calc
    import uart_rx_timeout_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int CHAR_COUNT    = 4,
    localparam int LIM_W = $clog2(window_max(TICKS_PER_BIT, CHAR_COUNT) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_fmt_t       fmt_i,
    output logic [LIM_W-1:0] limit_o,
    output logic             fmt_chg_o
);
    localparam int LIM_LO = CHAR_COUNT * TICKS_PER_BIT * 7;
    localparam int LIM_HI = window_max(TICKS_PER_BIT, CHAR_COUNT);

    frame_fmt_t       fmt_q;
    logic [LIM_W-1:0] limit_q;

    always_ff @(posedge clk) begin
        fmt_q   <= fmt_i;
        limit_q <= LIM_W'(window_ticks(fmt_i, TICKS_PER_BIT, CHAR_COUNT));
        if (rst) begin
            fmt_q <= fmt_i;
        end
    end

    assign fmt_chg_o = (fmt_i != fmt_q);
    assign limit_o   = limit_q;

    // R4: the window stays between the shortest and longest frame.
    assert_limit_range_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(limit_q) >= LIM_LO) && (int'(limit_q) <= LIM_HI));

endmodule

// File: rtl/tmo_tick_counter.sv
module tmo_tick_counter #(
    parameter int LIM_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic [LIM_W-1:0] cnt_o,
    output logic             hit_o
);
    logic [LIM_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q < limit_i)) begin
            cnt_q <= cnt_q + LIM_W'(1);
        end
    end

    assign hit_o = !restart_i && tick_i && (cnt_q == limit_i - LIM_W'(1));
    assign cnt_o = cnt_q;

    // R5: the count moves by at most one per cycle and only on a tick.
    assert_step_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !restart_i) |=> $stable(cnt_q));

    // R4: the count saturates at the window and never passes it.
    assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(limit_i) || (cnt_q <= limit_i));

endmodule

// File: rtl/tmo_irq_latch.sv
module tmo_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            irq_q <= 1'b0;
        end else if (set_i) begin
            irq_q <= 1'b1;
        end
    end

    assign irq_o = irq_q;

    // R7: without a clear, a raised interrupt holds.
    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !clr_i) |=> irq_q);

endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout
    import uart_rx_timeout_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int CHAR_COUNT    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic [1:0] word_len_i,
    input  logic       parity_en_i,
    input  logic [1:0] stop_sel_i,
    input  logic       fifo_empty_i,
    input  logic       stop_mid_i,
    input  logic       rhr_rd_i,
    output logic       timeout_irq_o
);
    localparam int LIM_W = $clog2(window_max(TICKS_PER_BIT, CHAR_COUNT) + 1);

    frame_fmt_t       fmt;
    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] cnt;
    logic             fmt_chg;
    logic             restart;
    logic             hit;
    logic             clr;

    always_comb begin
        fmt.wlen = word_len_i;
        fmt.par  = parity_en_i;
        fmt.stop = stop_len_e'(stop_sel_i);
    end

    assign clr     = rhr_rd_i || fifo_empty_i;
    assign restart = clr || stop_mid_i || fmt_chg;

    tmo_limit_calc #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .CHAR_COUNT   (CHAR_COUNT)
    ) u_limit (
        .clk      (clk),
        .rst      (rst),
        .fmt_i    (fmt),
        .limit_o  (limit),
        .fmt_chg_o(fmt_chg)
    );

    tmo_tick_counter #(
        .LIM_W(LIM_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .restart_i(restart),
        .limit_i  (limit),
        .cnt_o    (cnt),
        .hit_o    (hit)
    );

    tmo_irq_latch u_irq (
        .clk  (clk),
        .rst  (rst),
        .set_i(hit),
        .clr_i(clr),
        .irq_o(timeout_irq_o)
    );

    // R1: an empty FIFO silences the interrupt.
    assert_empty_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        fifo_empty_i |=> !timeout_irq_o);

    // R2: a stop-bit centre strobe zeroes the count.
    assert_mid_restart_R2: assert property (@(posedge clk) disable iff (rst)
        stop_mid_i |=> (cnt == '0));

    // R3: a holding-register read drops the interrupt.
    assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
        rhr_rd_i |=> !timeout_irq_o);

    // R4: the interrupt rises only on the last tick of a full window.
    assert_rise_at_limit_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_irq_o) |-> ($past(cnt) == $past(limit) - LIM_W'(1)));

    // R6: a new frame format zeroes the count.
    assert_fmt_restart_R6: assert property (@(posedge clk) disable iff (rst)
        fmt_chg |=> (cnt == '0));

    // R8: reset clears the interrupt and the count.
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!timeout_irq_o && (cnt == '0)));

endmodule

// File: tb/tb_uart_rx_timeout.sv
module tb_uart_rx_timeout;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_i;
    logic [1:0] word_len_i;
    logic       parity_en_i;
    logic [1:0] stop_sel_i;
    logic       fifo_empty_i;
    logic       stop_mid_i;
    logic       rhr_rd_i;
    logic       timeout_irq_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    uart_rx_timeout dut (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .word_len_i   (word_len_i),
        .parity_en_i  (parity_en_i),
        .stop_sel_i   (stop_sel_i),
        .fifo_empty_i (fifo_empty_i),
        .stop_mid_i   (stop_mid_i),
        .rhr_rd_i     (rhr_rd_i),
        .timeout_irq_o(timeout_irq_o)
    );

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: timeout_irq_o=%0b expected %0b", req, act, exp);
        end
    endtask

    // One clock: drive at a falling edge, result visible at the next one.
    task automatic cyc(input logic t, input logic rd, input logic mid);
        tick_i     = t;
        rhr_rd_i   = rd;
        stop_mid_i = mid;
        @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0);
    endtask

    task automatic kick();
        cyc(1'b0, 1'b1, 1'b0);
    endtask

    function automatic int exp_lim(input int wl, input int par, input int st);
        int s;
        s = (st == 0) ? 16 : (st == 1) ? 24 : 32;
        return 4 * (16 * (1 + 5 + wl + par) + s);
    endfunction

    task automatic set_fmt(input int wl, input int par, input int st);
        word_len_i  = 2'(wl);
        parity_en_i = 1'(par);
        stop_sel_i  = 2'(st);
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) cyc(1'b1, 1'b0, 1'b0);
        check(timeout_irq_o, 1'b0, "R8 reset state");
        rst = 1'b0;
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_limit(input int wl, input int par, input int st);
        int lim;
        lim = exp_lim(wl, par, st);
        set_fmt(wl, par, st);
        kick();
        run_ticks(lim - 1);
        check(timeout_irq_o, 1'b0, $sformatf("R4 one tick short lim=%0d", lim));
        run_ticks(1);
        check(timeout_irq_o, 1'b1, $sformatf("R4 at limit lim=%0d", lim));
        kick();
        check(timeout_irq_o, 1'b0, "R3 read clears");
    endtask

    task automatic t_empty();
        int lim;
        lim = exp_lim(3, 0, 0);
        set_fmt(3, 0, 0);
        kick();
        run_ticks(lim);
        check(timeout_irq_o, 1'b1, "R1 setup raised");
        fifo_empty_i = 1'b1;
        cyc(1'b1, 1'b0, 1'b0);
        check(timeout_irq_o, 1'b0, "R1 empty clears");
        run_ticks(2 * lim);
        check(timeout_irq_o, 1'b0, "R1 empty stays quiet");
        fifo_empty_i = 1'b0;
        run_ticks(lim - 1);
        check(timeout_irq_o, 1'b0, "R1 count restarted after empty");
    endtask

    task automatic t_gaps();
        int lim;
        lim = exp_lim(3, 0, 0);
        set_fmt(3, 0, 0);
        kick();
        for (int i = 0; i < 2 * (lim - 1); i++) cyc(1'((i % 2) == 0), 1'b0, 1'b0);
        check(timeout_irq_o, 1'b0, "R5 sparse ticks short");
        for (int i = 0; i < 50; i++) cyc(1'b0, 1'b0, 1'b0);
        check(timeout_irq_o, 1'b0, "R5 idle cycles do not count");
        cyc(1'b1, 1'b0, 1'b0);
        check(timeout_irq_o, 1'b1, "R5 last sparse tick fires");
        kick();
    endtask

    task automatic t_mid_and_sticky();
        int lim;
        lim = exp_lim(3, 0, 0);
        set_fmt(3, 0, 0);
        kick();
        run_ticks(600);
        cyc(1'b1, 1'b0, 1'b1);
        run_ticks(lim - 1);
        check(timeout_irq_o, 1'b0, "R2 stop centre restarts");
        run_ticks(1);
        check(timeout_irq_o, 1'b1, "R2 fires after full window");
        cyc(1'b1, 1'b0, 1'b1);
        check(timeout_irq_o, 1'b1, "R7 stop centre keeps irq");
        run_ticks(100);
        check(timeout_irq_o, 1'b1, "R7 irq held");
        kick();
        check(timeout_irq_o, 1'b0, "R3 read releases held irq");
    endtask

    task automatic t_read_restart();
        int lim;
        lim = exp_lim(3, 0, 0);
        kick();
        run_ticks(600);
        kick();
        run_ticks(lim - 1);
        check(timeout_irq_o, 1'b0, "R3 read restarts count");
        run_ticks(1);
        check(timeout_irq_o, 1'b1, "R3 fires after full window");
        kick();
    endtask

    task automatic t_fmt_change();
        int lim;
        set_fmt(3, 0, 0);
        kick();
        run_ticks(600);
        lim = exp_lim(0, 0, 0);
        set_fmt(0, 0, 0);
        run_ticks(lim - 1);
        check(timeout_irq_o, 1'b0, "R6 format change restarts");
        run_ticks(1);
        check(timeout_irq_o, 1'b1, "R6 new limit applies");
        kick();
    endtask

    task automatic t_reset_mid();
        int lim;
        lim = exp_lim(3, 0, 0);
        set_fmt(3, 0, 0);
        kick();
        run_ticks(lim);
        check(timeout_irq_o, 1'b1, "R8 setup raised");
        rst = 1'b1;
        cyc(1'b1, 1'b0, 1'b0);
        check(timeout_irq_o, 1'b0, "R8 reset drops irq");
        rst = 1'b0;
        run_ticks(lim - 1);
        check(timeout_irq_o, 1'b0, "R8 count cleared by reset");
        run_ticks(1);
        check(timeout_irq_o, 1'b1, "R8 full window after reset");
        kick();
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; tick_i = 1'b0; rhr_rd_i = 1'b0; stop_mid_i = 1'b0;
        word_len_i = 2'd3; parity_en_i = 1'b0; stop_sel_i = 2'd0;
        fifo_empty_i = 1'b0;
        @(negedge clk);
        t_reset();
        t_limit(3, 0, 0);
        t_limit(0, 0, 1);
        t_limit(2, 1, 2);
        t_limit(0, 1, 0);
        t_limit(3, 1, 3);
        t_empty();
        t_gaps();
        t_mid_and_sticky();
        t_read_restart();
        t_fmt_change();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule